// File: doc/BRIEF.md
# Paged Register Port over SPI

This block is a serial slave port that reads and writes a bank of 8-bit control registers split into pages. A host drives the serial clock with an idle-low level and runs the port in SPI mode 1. The host changes MOSI on each rising SCLK edge, and the port samples it on the falling edge that follows. Every frame opens with a command byte. The command holds a 7-bit register address and a direction flag. A write frame then carries one data byte into the addressed register. A read frame returns the register contents on MISO during the second byte.

Address 0 is the page selector on every page. Writing it picks which page the addresses 1 to 127 reach in later frames. Reading it returns the current page number. The serial inputs are brought into the system clock domain through synchronizers, so the serial clock must be several times slower than the system clock. Only the first command after slave-select falls counts. Any bits the host keeps clocking after that command and its data byte are ignored until slave-select rises and falls again. MISO is a data/enable pair, and the pad above the block tri-states the line whenever the enable is low.

The frame controller is a state machine with five states:
- **IDLE** waits for slave-select to fall.
- **CMD** collects the command byte.
- **WDATA** collects the write byte.
- **RDATA** shifts out the read byte.
- **HOLD** ignores everything until the frame ends.

The transitions are:
- IDLE→CMD when slave-select falls.
- CMD→WDATA on the eighth capture with direction 0.
- CMD→RDATA on the eighth capture with direction 1.
- WDATA→HOLD and RDATA→HOLD on the eighth capture of the second byte.
- Any state→IDLE when slave-select rises.

Top module: `spi_paged_regs`

## Requirements
- R1: MOSI is captured on falling SCLK edges, most significant bit first. MISO changes only after rising SCLK edges.
- R2: In the command byte, bits 7 to 1 carry the register address and bit 0 is the direction: 0 writes, 1 reads. A read frame never modifies a register, whatever MOSI carries during its second byte.
- R3: In a write frame, the second byte is stored in the addressed register of the active page. The store lands a system clock after the synchronized 16th falling SCLK edge, before slave-select rises.
- R4: In a read frame, the addressed register of the active page appears on MISO, most significant bit first, one bit after each of rising edges 9 to 16.
- R5: The MISO enable is low while slave-select is high and during the command byte. It is high from rising edge 9 of a read frame until that frame's 16th falling edge.
- R6: After the first command and its optional data byte, further SCLK bits in the same frame cause no register access and do not enable MISO. This holds until slave-select rises and falls again.
- R7: If slave-select rises before the 16th falling edge of a write frame, no register is modified.
- R8: Address 0 is the page selector on every page. A write to it keeps only bit 0 (0xFF selects page 1, 0x02 selects page 0). A read of it returns the page number zero-extended to 8 bits.
- R9: After reset the active page is 0, addresses 1 to 127 of both pages hold 0x00, and the MISO enable is low.
- R10: The same address on page 0 and page 1 names two separate registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host, idle low |
| ss_ni | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | MISO pad enable; low means the pad is tri-stated |

## Verification
The bench uses the default parameters: a 7-bit address, 8-bit data, two pages and two synchronizer stages. This configuration is small enough that every register address 1 to 127 on both pages is written with a pattern computed from page and address, and then read back through the page selector. Around that sweep the bench exercises the corner cases of the frame controller. These are trailing bytes in a single select window, write frames cut short, read frames that carry data on MOSI, and the masking of the page selector value.

// File: rtl/spi_pg_pkg.sv
package spi_pg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WDATA,
        ST_RDATA,
        ST_HOLD
    } frame_state_e;

endpackage

// File: rtl/spi_pg_sync.sv
module spi_pg_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sclk_i,
    input  logic ss_ni,
    input  logic mosi_i,
    output logic sclk_rise_o,
    output logic sclk_fall_o,
    output logic ss_fall_o,
    output logic ss_rise_o,
    output logic ss_high_o,
    output logic mosi_o
);
    // bit 0 = sclk, bit 1 = slave select, bit 2 = mosi
    localparam int             NSIG    = 3;
    localparam logic [NSIG-1:0] IDLE_V = 3'b010;

    logic [SYNC_STAGES-1:0][NSIG-1:0] stage_q;
    logic [NSIG-1:0]                  last_q;
    logic [NSIG-1:0]                  now_s;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int s = 0; s < SYNC_STAGES; s++) begin
                stage_q[s] <= IDLE_V;
            end
            last_q <= IDLE_V;
        end else begin
            stage_q[0] <= {mosi_i, ss_ni, sclk_i};
            for (int s = 1; s < SYNC_STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
            last_q <= stage_q[SYNC_STAGES-1];
        end
    end

    assign now_s       = stage_q[SYNC_STAGES-1];
    assign sclk_rise_o = now_s[0] & ~last_q[0];
    assign sclk_fall_o = ~now_s[0] & last_q[0];
    assign ss_fall_o   = ~now_s[1] & last_q[1];
    assign ss_rise_o   = now_s[1] & ~last_q[1];
    assign ss_high_o   = now_s[1];
    assign mosi_o      = now_s[2];

endmodule

// File: rtl/spi_pg_frame.sv
module spi_pg_frame
    import spi_pg_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sclk_rise_i,
    input  logic              sclk_fall_i,
    input  logic              ss_fall_i,
    input  logic              ss_rise_i,
    input  logic              ss_high_i,
    input  logic              mosi_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              miso_o,
    output logic              miso_oe_o
);
    localparam int CMD_W = ADDR_W + 1;
    localparam int SH_W  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int CNT_W = $clog2(SH_W);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    frame_state_e      state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [SH_W-1:0]   shift_q;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_en_q;
    logic [DATA_W-1:0] wr_data_q;
    logic              drive_q;
    logic              miso_q;
    logic [DATA_W-1:0] rd_sh_q;
    logic              capturing;
    logic              cmd_done, data_done;

    assign capturing = sclk_fall_i &&
                       (state_q == ST_CMD || state_q == ST_WDATA || state_q == ST_RDATA);
    assign cmd_done  = sclk_fall_i && (state_q == ST_CMD) && (cnt_q == CMD_LAST);
    assign data_done = sclk_fall_i && (state_q == ST_WDATA || state_q == ST_RDATA)
                       && (cnt_q == DATA_LAST);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (ss_rise_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (ss_fall_i) state_d = ST_CMD;
                ST_CMD:   if (cmd_done) state_d = mosi_i ? ST_RDATA : ST_WDATA;
                ST_WDATA: if (data_done) state_d = ST_HOLD;
                ST_RDATA: if (data_done) state_d = ST_HOLD;
                ST_HOLD:  state_d = ST_HOLD;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // capture path: bit counter, shifter, decoded command, write strobe
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q     <= '0;
            shift_q   <= '0;
            addr_q    <= '0;
            wr_en_q   <= 1'b0;
            wr_data_q <= '0;
        end else begin
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (capturing) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (capturing) begin
                shift_q <= {shift_q[SH_W-2:0], mosi_i};
            end
            if (cmd_done && !ss_rise_i) begin
                addr_q <= shift_q[ADDR_W-1:0];
            end
            wr_en_q <= data_done && (state_q == ST_WDATA) && !ss_rise_i;
            if (data_done && state_q == ST_WDATA) begin
                wr_data_q <= {shift_q[DATA_W-2:0], mosi_i};
            end
        end
    end

    // output process: MISO launch on rising edges during RDATA
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            drive_q <= 1'b0;
            miso_q  <= 1'b0;
            rd_sh_q <= '0;
        end else if (state_d != ST_RDATA) begin
            drive_q <= 1'b0;
        end else if (state_q == ST_RDATA && sclk_rise_i) begin
            drive_q <= 1'b1;
            if (!drive_q) begin
                miso_q  <= rd_data_i[DATA_W-1];
                rd_sh_q <= {rd_data_i[DATA_W-2:0], 1'b0};
            end else begin
                miso_q  <= rd_sh_q[DATA_W-1];
                rd_sh_q <= {rd_sh_q[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign addr_o    = addr_q;
    assign wr_en_o   = wr_en_q;
    assign wr_data_o = wr_data_q;
    assign miso_o    = miso_q;
    assign miso_oe_o = drive_q;

    // R5: enable stays low once deselect has settled
    a_r5_quiet_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ss_high_i && $past(ss_high_i)) |-> !miso_oe_o);
    // R5: enable low throughout the command byte
    a_r5_quiet_in_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_CMD) |-> !miso_oe_o);
    // R4: MISO is only driven while returning read data
    a_r4_drive_in_rdata: assert property (@(posedge clk_i) disable iff (!rst_ni)
        miso_oe_o |-> (state_q == ST_RDATA));
    // R6: a write strobe is a single pulse that coincides with entering HOLD
    a_r6_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_q |-> (state_q == ST_HOLD) ##1 !wr_en_q);
    // R6: HOLD is left only towards IDLE
    a_r6_hold_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(state_q) == ST_HOLD && state_q != ST_HOLD) |-> (state_q == ST_IDLE));
    // R1: MISO data changes only after a rising serial clock edge
    a_r1_launch_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (miso_oe_o && $past(miso_oe_o) && !$stable(miso_q)) |-> $past(sclk_rise_i));

endmodule

// File: rtl/spi_pg_regbank.sv
module spi_pg_regbank #(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 8,
    parameter int NUM_PAGES = 2   // power of two
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int PAGE_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [PAGE_W-1:0] page_q;
    logic [DATA_W-1:0] regs_q [NUM_PAGES][DEPTH];
    logic              sel_page;

    assign sel_page = (addr_i == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            page_q <= '0;
            for (int p = 0; p < NUM_PAGES; p++) begin
                for (int a = 0; a < DEPTH; a++) begin
                    regs_q[p][a] <= '0;
                end
            end
        end else if (wr_en_i) begin
            if (sel_page) begin
                page_q <= wr_data_i[PAGE_W-1:0];
            end else begin
                regs_q[page_q][addr_i] <= wr_data_i;
            end
        end
    end

    assign rd_data_o = sel_page ? {{(DATA_W-PAGE_W){1'b0}}, page_q}
                                : regs_q[page_q][addr_i];

    // R8: a page-select write leaves only the masked value
    a_r8_page_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(wr_en_i) && $past(addr_i) == '0) |-> (page_q == $past(wr_data_i[PAGE_W-1:0])));
    // R8: page changes only through a write
    a_r8_page_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(wr_en_i) |-> $stable(page_q));

endmodule

// File: rtl/spi_paged_regs.sv
module spi_paged_regs #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int NUM_PAGES   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sclk_i,
    input  logic ss_ni,
    input  logic mosi_i,
    output logic miso_o,
    output logic miso_oe_o
);
    logic              sclk_rise, sclk_fall, ss_fall, ss_rise, ss_high, mosi_s;
    logic [ADDR_W-1:0] addr;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data, rd_data;

    spi_pg_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) sync_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sclk_i      (sclk_i),
        .ss_ni       (ss_ni),
        .mosi_i      (mosi_i),
        .sclk_rise_o (sclk_rise),
        .sclk_fall_o (sclk_fall),
        .ss_fall_o   (ss_fall),
        .ss_rise_o   (ss_rise),
        .ss_high_o   (ss_high),
        .mosi_o      (mosi_s)
    );

    spi_pg_frame #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) frame_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sclk_rise_i (sclk_rise),
        .sclk_fall_i (sclk_fall),
        .ss_fall_i   (ss_fall),
        .ss_rise_i   (ss_rise),
        .ss_high_i   (ss_high),
        .mosi_i      (mosi_s),
        .rd_data_i   (rd_data),
        .addr_o      (addr),
        .wr_en_o     (wr_en),
        .wr_data_o   (wr_data),
        .miso_o      (miso_o),
        .miso_oe_o   (miso_oe_o)
    );

    spi_pg_regbank #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .NUM_PAGES (NUM_PAGES)
    ) bank_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .addr_i    (addr),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data)
    );

    // R9: enable is low in the first cycle after reset
    a_r9_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> !miso_oe_o);

endmodule

// File: tb/spi_paged_regs_tb_top.sv
`timescale 1ns/1ps
module spi_paged_regs_tb_top;

    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic ss_n = 1'b1;
    logic mosi = 1'b0;
    logic miso, miso_oe;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    spi_paged_regs dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .sclk_i    (sclk),
        .ss_ni     (ss_n),
        .mosi_i    (mosi),
        .miso_o    (miso),
        .miso_oe_o (miso_oe)
    );

    function automatic logic [7:0] pat(int p, int a);
        return 8'(a * 37 + p * 101 + 3);
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // shifts nb bits of tx (MSB first); rx collects MISO, oe flags summarize the enable
    task automatic shift(input logic [7:0] tx, input int nb, output logic [7:0] rx,
                         output logic oe_all, output logic oe_any);
        rx = '0; oe_all = 1'b1; oe_any = 1'b0;
        for (int i = 7; i > 7 - nb; i--) begin
            sclk = 1'b1; mosi = tx[i];
            tick(HALF);
            rx[i] = miso;
            oe_all &= miso_oe; oe_any |= miso_oe;
            sclk = 1'b0;
            tick(HALF);
        end
    endtask

    task automatic sel();
        ss_n = 1'b0; tick(HALF);
    endtask

    task automatic desel();
        tick(HALF); ss_n = 1'b1; tick(2 * HALF);
    endtask

    task automatic wr_reg(int a, logic [7:0] d);
        logic [7:0] rx; logic x, y;
        sel();
        shift({7'(a), 1'b0}, 8, rx, x, y);
        shift(d, 8, rx, x, y);
        desel();
    endtask

    task automatic rd_reg(int a, output logic [7:0] d, output logic [1:0] oe);
        logic [7:0] rx; logic x, cmd_any, dat_all;
        sel();
        shift({7'(a), 1'b1}, 8, rx, x, cmd_any);
        shift(8'h00, 8, d, dat_all, x);
        desel();
        oe = {dat_all, cmd_any};
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, rx;
        logic [1:0] oe;
        logic       x, y;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R9: reset state
        chk("R9 oe after reset", {7'b0, miso_oe}, 8'h00);
        rd_reg(0, d, oe);  chk("R9 page after reset", d, 8'h00);
        rd_reg(1, d, oe);  chk("R9 reg1 page0 reset", d, 8'h00);
        rd_reg(127, d, oe); chk("R9 reg127 page0 reset", d, 8'h00);
        wr_reg(0, 8'h01);
        rd_reg(64, d, oe); chk("R9 reg64 page1 reset", d, 8'h00);

        // R3/R10: write every address on both pages
        for (int p = 0; p < 2; p++) begin
            wr_reg(0, 8'(p));
            for (int a = 1; a < 128; a++) wr_reg(a, pat(p, a));
        end
        // R1/R4/R5/R8/R10: read back through the page selector
        for (int p = 0; p < 2; p++) begin
            wr_reg(0, 8'(p));
            rd_reg(0, d, oe); chk("R8 page readback", d, 8'(p));
            for (int a = 1; a < 128; a++) begin
                rd_reg(a, d, oe);
                chk("R4 R10 sweep readback", d, pat(p, a));
                chk("R5 enable in cmd/data", {6'b0, oe}, 8'h02);
            end
        end

        // R8: only bit 0 of the page value is kept
        wr_reg(0, 8'hFF);
        rd_reg(0, d, oe);  chk("R8 mask 0xFF", d, 8'h01);
        rd_reg(5, d, oe);  chk("R8 page1 after 0xFF", d, pat(1, 5));
        wr_reg(0, 8'h02);
        rd_reg(0, d, oe);  chk("R8 mask 0x02", d, 8'h00);
        rd_reg(5, d, oe);  chk("R8 page0 after 0x02", d, pat(0, 5));

        // R6: trailing write frame in the same select window is ignored
        sel();
        shift({7'd10, 1'b0}, 8, rx, x, y);
        shift(8'hA5, 8, rx, x, y);
        shift({7'd11, 1'b0}, 8, rx, x, y);
        shift(8'h5A, 8, rx, x, y);
        shift({7'd0, 1'b0}, 8, rx, x, y);
        shift(8'h01, 8, rx, x, y);
        desel();
        rd_reg(10, d, oe); chk("R3 first write lands", d, 8'hA5);
        rd_reg(11, d, oe); chk("R6 trailing write ignored", d, pat(0, 11));
        rd_reg(0, d, oe);  chk("R6 trailing page write ignored", d, 8'h00);

        // R6: bytes after a read do not write and do not drive MISO
        sel();
        shift({7'd12, 1'b1}, 8, rx, x, y);
        shift(8'h00, 8, rx, x, y);
        chk("R4 read in long frame", rx, pat(0, 12));
        shift({7'd12, 1'b0}, 8, rx, x, y);
        shift(8'h00, 8, rx, x, y);
        chk("R6 no enable after read byte", {7'b0, y}, 8'h00);
        desel();
        rd_reg(12, d, oe); chk("R6 trailing after read ignored", d, pat(0, 12));

        // R2: a read frame carrying data on MOSI modifies nothing
        sel();
        shift({7'd30, 1'b1}, 8, rx, x, y);
        shift(8'hFF, 8, rx, x, y);
        desel();
        rd_reg(30, d, oe); chk("R2 read frame no write", d, pat(0, 30));

        // R7: write frame cut short
        sel();
        shift({7'd20, 1'b0}, 8, rx, x, y);
        shift(8'h3C, 5, rx, x, y);
        sclk = 1'b0;
        desel();
        rd_reg(20, d, oe); chk("R7 short frame no write", d, pat(0, 20));
        sel();
        shift({7'd21, 1'b0}, 7, rx, x, y);
        shift(8'h00, 8, rx, x, y);
        desel();
        rd_reg(21, d, oe); chk("R7 short frame then ok", d, pat(0, 21));
        wr_reg(21, 8'hC3);
        rd_reg(21, d, oe); chk("R3 write after cut frame", d, 8'hC3);

        chk("R5 oe idle at end", {7'b0, miso_oe}, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule